// File: doc/BRIEF.md
# Backplane Time-Slot Serial Port

This block links a line-interface device to a line-card backplane over a four-wire serial bus. The bus is a data clock, a frame sync, a downstream data line into the block and an upstream data line out of it. Each frame holds eight time slots of 32 bits, sent at 2048 kbit/s in each direction. A static select input names the one slot that the port owns.

Inside the owned slot the port shifts in 32 downstream bits. At the end of the slot it hands them over as four parallel bytes, together with a one-cycle valid strobe. It also shifts out four parallel upstream bytes, which it takes in at the first bit of the slot. The upstream line is driven only during the owned slot and floats at all other times.

The four bytes of a slot are, in transmission order:
- a PCM byte;
- a spare byte;
- a monitor byte;
- a signalling byte made of a 6-bit command field, an acknowledge flag and a monitor-pending flag.

The block does not interpret the monitor or signalling contents. A separate block handles them.

Top module: `gci_slot_port`

## Requirements
- R1: A frame is 256 bit times: slot n holds bits 32n to 32n+31, with n compared against `slot_sel` (3 bits, 0 to 7). The bit counter returns to bit 0 at the first falling clock edge that sees `fsc` high after it was low. That edge is the position of bit 0 of slot 0, and the counter then counts on from it.
- R2: Every byte is carried most significant bit first. Slot order is B1 (bits 31:24 of the slot word), B2 (23:16), monitor (15:8), then the signalling byte. In the signalling byte, the command field takes word bits 7:2, the acknowledge flag bit 1 and the monitor-pending flag bit 0.
- R3: `dd` is sampled on falling clock edges. The falling edge that samples the last bit of the owned slot also loads the `rx_*` outputs and raises `rx_valid`. `rx_valid` stays high for exactly one clock period, once per frame.
- R4: Upstream bits change on rising clock edges. The bit sent in bit time k of the owned slot is bit 31-k of the transmit word.
- R5: `du_oe` is high, and `du` is driven, exactly during the 32 bit times of the owned slot. At all other times `du_oe` is low and `du` is high impedance.
- R6: The transmit word is captured at the rising edge that starts bit 0 of the owned slot. Changes to the `tx_*` inputs later in the slot have no effect on that slot's upstream bits.
- R7: With `rate_x2` high, the clock runs at twice the bit rate and each bit lasts two clock periods. The frame sync rise marks the first of those two periods. `dd` is sampled on the falling edge of the second period, and `du` changes only at the rising edge that starts a bit.
- R8: While `rst_n` is low, `du_oe` and `rx_valid` are low, all `rx_*` bytes are zero and the held upstream word is all zeros.
- R9: After reset, nothing is received or driven until the first frame sync rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dcl | input | 1 | Data clock, 1x or 2x the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsc | input | 1 | 8 kHz frame sync, rising edge marks slot 0 bit 0 |
| rate_x2 | input | 1 | 1 = clock at twice the bit rate |
| slot_sel | input | 3 | Owned time slot |
| dd | input | 1 | Downstream serial data |
| du | output | 1 | Upstream serial data, high impedance outside the slot |
| du_oe | output | 1 | High while du is driven |
| tx_b1 | input | 8 | Upstream PCM byte |
| tx_b2 | input | 8 | Upstream spare byte |
| tx_mon | input | 8 | Upstream monitor byte |
| tx_cmd | input | 6 | Upstream command field |
| tx_ack | input | 1 | Upstream acknowledge flag |
| tx_mflag | input | 1 | Upstream monitor-pending flag |
| rx_b1 | output | 8 | Received PCM byte |
| rx_b2 | output | 8 | Received spare byte |
| rx_mon | output | 8 | Received monitor byte |
| rx_cmd | output | 6 | Received command field |
| rx_ack | output | 1 | Received acknowledge flag |
| rx_mflag | output | 1 | Received monitor-pending flag |
| rx_valid | output | 1 | One-period strobe when the rx bytes update |

## Verification
The bench owns slots 0 and 7, which sit at the frame edges. With a wrong wrap or an off-by-one slot decode, the port would drive the wrong 32 bits or would miss the last slot's strobe across the frame boundary.

It changes the transmit inputs in the middle of each slot. A port that shifted the live inputs instead of a captured copy would then send the inverted tail of the word.

It switches to double-rate clocking and back between frames. A wrong phase alignment would sample each bit one period early or would change `du` halfway through a bit.

It runs idle clocks after reset with no frame sync, and starts the first frame at an arbitrary count. A port that did not wait for the sync, or that did not restart its counter on it, would drive or strobe at the wrong place.

// File: rtl/gci_pkg.sv
package gci_pkg;

    // bit position inside a 2x-rate bit: first or second clock period
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } bit_phase_e;

    // one time slot, packed in transmission order (MSB goes first)
    typedef struct packed {
        logic [7:0] b1;
        logic [7:0] b2;
        logic [7:0] mon;
        logic [5:0] cmd;
        logic       ack;
        logic       mflag;
    } slot_word_t;

    localparam int SLOT_BITS = $bits(slot_word_t);

endpackage

// File: rtl/gci_slot_timer.sv
module gci_slot_timer
    import gci_pkg::*;
#(
    parameter  int NUM_SLOTS  = 8,
    localparam int FRAME_BITS = NUM_SLOTS * SLOT_BITS,
    localparam int CNT_W      = $clog2(FRAME_BITS)
) (
    input  logic             dcl,
    input  logic             rst_n,
    input  logic             fsc,
    input  logic             rate_x2,
    output logic [CNT_W-1:0] edge_idx,
    output bit_phase_e       edge_ph,
    output logic             edge_sync,
    output logic [CNT_W-1:0] next_idx,
    output bit_phase_e       next_ph,
    output logic             sync_q
);

    typedef struct packed {
        logic [CNT_W-1:0] idx;
        bit_phase_e       ph;
        logic             fsc_prev;
        logic             synced;
    } tmr_t;

    tmr_t             st_d, st_q;
    logic             fsc_rise;
    logic [CNT_W-1:0] inc_idx;

    always_comb begin
        fsc_rise = fsc && !st_q.fsc_prev;
        inc_idx  = (st_q.idx == CNT_W'(FRAME_BITS - 1)) ? '0 : st_q.idx + CNT_W'(1);

        // free-running advance from the last falling edge
        if (!rate_x2) begin
            next_idx = inc_idx;
            next_ph  = PH_SECOND;
        end else if (st_q.ph == PH_SECOND) begin
            next_idx = inc_idx;
            next_ph  = PH_FIRST;
        end else begin
            next_idx = st_q.idx;
            next_ph  = PH_SECOND;
        end

        st_d          = st_q;
        st_d.fsc_prev = fsc;
        if (fsc_rise) begin
            st_d.idx    = '0;
            st_d.ph     = rate_x2 ? PH_FIRST : PH_SECOND;
            st_d.synced = 1'b1;
        end else begin
            st_d.idx = next_idx;
            st_d.ph  = next_ph;
        end
    end

    always_ff @(negedge dcl or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{idx: CNT_W'(FRAME_BITS - 1), ph: PH_SECOND, fsc_prev: 1'b0, synced: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign edge_idx  = st_d.idx;
    assign edge_ph   = st_d.ph;
    assign edge_sync = st_d.synced;
    assign sync_q    = st_q.synced;

    // frame sync rise restarts the count at bit 0
    assert_sync_restart_R1: assert property (@(negedge dcl) disable iff (!rst_n)
        (fsc && !st_q.fsc_prev) |=> (st_q.idx == '0 && st_q.synced));

endmodule

// File: rtl/gci_rx_deser.sv
module gci_rx_deser
    import gci_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             dcl,
    input  logic             rst_n,
    input  logic             dd,
    input  logic [SEL_W-1:0] slot_sel,
    input  logic [CNT_W-1:0] edge_idx,
    input  bit_phase_e       edge_ph,
    input  logic             edge_sync,
    output slot_word_t       rx_word,
    output logic             rx_valid
);

    localparam int LOW_W = CNT_W - SEL_W;

    typedef struct packed {
        logic [SLOT_BITS-1:0] shift;
        slot_word_t           word;
        logic                 valid;
    } rx_t;

    rx_t  st_d, st_q;
    logic take, last;

    always_comb begin
        take = edge_sync && (edge_ph == PH_SECOND)
            && (edge_idx[CNT_W-1 -: SEL_W] == slot_sel);
        last = &edge_idx[LOW_W-1:0];

        st_d       = st_q;
        st_d.valid = 1'b0;
        if (take) begin
            st_d.shift = {st_q.shift[SLOT_BITS-2:0], dd};
            if (last) begin
                st_d.word  = {st_q.shift[SLOT_BITS-2:0], dd};
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(negedge dcl or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_word  = st_q.word;
    assign rx_valid = st_q.valid;

    // strobe lasts a single period
    assert_valid_single_R3: assert property (@(negedge dcl) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);

endmodule

// File: rtl/gci_tx_ser.sv
module gci_tx_ser
    import gci_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             dcl,
    input  logic             rst_n,
    input  logic             rate_x2,
    input  logic [SEL_W-1:0] slot_sel,
    input  logic [CNT_W-1:0] next_idx,
    input  bit_phase_e       next_ph,
    input  logic             sync_q,
    input  slot_word_t       tx_word,
    output logic             du_bit,
    output logic             du_oe
);

    localparam int LOW_W = CNT_W - SEL_W;

    typedef struct packed {
        logic [SLOT_BITS-1:0] shift;
        logic                 bit_v;
        logic                 oe;
    } tx_t;

    tx_t                  st_d, st_q;
    logic                 start, in_slot, first;
    logic [SLOT_BITS-1:0] tx_vec;

    always_comb begin
        tx_vec  = tx_word;
        start   = !rate_x2 || (next_ph == PH_FIRST);
        in_slot = sync_q && (next_idx[CNT_W-1 -: SEL_W] == slot_sel);
        first   = (next_idx[LOW_W-1:0] == '0);

        st_d = st_q;
        if (start) begin
            if (in_slot && first) begin
                st_d.bit_v = tx_vec[SLOT_BITS-1];
                st_d.shift = {tx_vec[SLOT_BITS-2:0], 1'b0};
                st_d.oe    = 1'b1;
            end else if (in_slot && st_q.oe) begin
                st_d.bit_v = st_q.shift[SLOT_BITS-1];
                st_d.shift = {st_q.shift[SLOT_BITS-2:0], 1'b0};
                st_d.oe    = 1'b1;
            end else begin
                st_d.bit_v = 1'b0;
                st_d.oe    = 1'b0;
            end
        end
    end

    always_ff @(posedge dcl or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign du_bit = st_q.bit_v;
    assign du_oe  = st_q.oe;

    // in 2x mode the second period of a bit never moves the line
    assert_hold_second_half_R7: assert property (@(posedge dcl) disable iff (!rst_n)
        (rate_x2 && next_ph == PH_SECOND) |=> ($stable(st_q.bit_v) && $stable(st_q.oe)));

endmodule

// File: rtl/gci_slot_port.sv
module gci_slot_port
    import gci_pkg::*;
#(
    parameter  int NUM_SLOTS = 8,
    localparam int SEL_W     = $clog2(NUM_SLOTS),
    localparam int CNT_W     = $clog2(NUM_SLOTS * SLOT_BITS)
) (
    input  logic             dcl,
    input  logic             rst_n,
    input  logic             fsc,
    input  logic             rate_x2,
    input  logic [SEL_W-1:0] slot_sel,
    input  logic             dd,
    output logic             du,
    output logic             du_oe,
    input  logic [7:0]       tx_b1,
    input  logic [7:0]       tx_b2,
    input  logic [7:0]       tx_mon,
    input  logic [5:0]       tx_cmd,
    input  logic             tx_ack,
    input  logic             tx_mflag,
    output logic [7:0]       rx_b1,
    output logic [7:0]       rx_b2,
    output logic [7:0]       rx_mon,
    output logic [5:0]       rx_cmd,
    output logic             rx_ack,
    output logic             rx_mflag,
    output logic             rx_valid
);

    logic [CNT_W-1:0] edge_idx, next_idx;
    bit_phase_e       edge_ph, next_ph;
    logic             edge_sync, sync_q, du_bit;
    slot_word_t       tx_word, rx_word;

    assign tx_word = '{b1: tx_b1, b2: tx_b2, mon: tx_mon, cmd: tx_cmd, ack: tx_ack, mflag: tx_mflag};

    gci_slot_timer #(.NUM_SLOTS(NUM_SLOTS)) u_timer (
        .dcl(dcl), .rst_n(rst_n), .fsc(fsc), .rate_x2(rate_x2),
        .edge_idx(edge_idx), .edge_ph(edge_ph), .edge_sync(edge_sync),
        .next_idx(next_idx), .next_ph(next_ph), .sync_q(sync_q)
    );

    gci_rx_deser #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_rx (
        .dcl(dcl), .rst_n(rst_n), .dd(dd), .slot_sel(slot_sel),
        .edge_idx(edge_idx), .edge_ph(edge_ph), .edge_sync(edge_sync),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    gci_tx_ser #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_tx (
        .dcl(dcl), .rst_n(rst_n), .rate_x2(rate_x2), .slot_sel(slot_sel),
        .next_idx(next_idx), .next_ph(next_ph), .sync_q(sync_q),
        .tx_word(tx_word), .du_bit(du_bit), .du_oe(du_oe)
    );

    assign du = du_oe ? du_bit : 1'bz;

    assign rx_b1    = rx_word.b1;
    assign rx_b2    = rx_word.b2;
    assign rx_mon   = rx_word.mon;
    assign rx_cmd   = rx_word.cmd;
    assign rx_ack   = rx_word.ack;
    assign rx_mflag = rx_word.mflag;

    // the driven bit always falls inside the owned slot of the timer
    assert_drive_in_slot_R5: assert property (@(negedge dcl) disable iff (!rst_n)
        du_oe |-> (edge_sync && edge_idx[CNT_W-1 -: SEL_W] == slot_sel));

endmodule

// File: tb/tb_gci_slot_port.sv
module tb_gci_slot_port;

    localparam int CLK_PERIOD = 20;

    logic       dcl = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsc = 1'b0;
    logic       rate_x2 = 1'b0;
    logic [2:0] slot_sel = 3'd0;
    logic       dd = 1'b0;
    wire        du;
    logic       du_oe;
    logic [7:0] tx_b1, tx_b2, tx_mon;
    logic [5:0] tx_cmd;
    logic       tx_ack, tx_mflag;
    logic [7:0] rx_b1, rx_b2, rx_mon;
    logic [5:0] rx_cmd;
    logic       rx_ack, rx_mflag, rx_valid;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];

    gci_slot_port dut (
        .dcl(dcl), .rst_n(rst_n), .fsc(fsc), .rate_x2(rate_x2), .slot_sel(slot_sel),
        .dd(dd), .du(du), .du_oe(du_oe),
        .tx_b1(tx_b1), .tx_b2(tx_b2), .tx_mon(tx_mon), .tx_cmd(tx_cmd),
        .tx_ack(tx_ack), .tx_mflag(tx_mflag),
        .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_mon(rx_mon), .rx_cmd(rx_cmd),
        .rx_ack(rx_ack), .rx_mflag(rx_mflag), .rx_valid(rx_valid)
    );

    always #(CLK_PERIOD / 2) dcl = ~dcl;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_tx(input logic [31:0] w);
        {tx_b1, tx_b2, tx_mon, tx_cmd, tx_ack, tx_mflag} = w;
    endtask

    function automatic logic [31:0] rx_vec();
        return {rx_b1, rx_b2, rx_mon, rx_cmd, rx_ack, rx_mflag};
    endfunction

    // scoreboard monitor: each strobe pops the oldest expected slot word
    initial begin
        forever begin
            @(posedge dcl);
            #(CLK_PERIOD / 4);
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    check("R3 unexpected rx_valid", 32'd1, 32'd0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check("R2 R3 rx word", rx_vec(), e);
                end
            end
        end
    end

    // driver: one frame, owned slot carries rxw downstream and txw upstream
    task automatic run_frame(input logic [2:0] sel, input logic x2,
                             input logic [31:0] rxw, input logic [31:0] txw);
        slot_sel = sel;
        rate_x2  = x2;
        set_tx(txw);
        exp_q.push_back(rxw);
        for (int b = 0; b < 256; b++) begin
            for (int ph = 0; ph < (x2 ? 2 : 1); ph++) begin
                logic in_s;
                in_s = ((b / 32) == int'(sel));
                @(posedge dcl);
                #1;
                if (ph == 0) begin
                    fsc = (b < 4);
                    dd  = in_s ? rxw[31 - (b % 32)] : 1'($urandom_range(0, 1));
                    // R6: disturb the inputs after the slot has started
                    if (in_s && (b % 32) == 8) set_tx(~txw);
                end
                @(negedge dcl);
                #(CLK_PERIOD / 4);
                check("R1 R5 du_oe", {31'd0, du_oe}, {31'd0, in_s});
                if (in_s) begin
                    check(x2 ? "R7 du bit" : "R4 R6 du bit",
                          {31'd0, du}, {31'd0, txw[31 - (b % 32)]});
                end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        set_tx(32'h0);
        repeat (3) @(posedge dcl);
        #1;
        check("R8 reset du_oe", {31'd0, du_oe}, 32'd0);
        check("R8 reset rx_valid", {31'd0, rx_valid}, 32'd0);
        check("R8 reset rx bytes", rx_vec(), 32'd0);
        rst_n = 1'b1;

        // R9: clocks without frame sync must neither drive nor deliver
        repeat (40) begin
            @(negedge dcl);
            #(CLK_PERIOD / 4);
            check("R9 du_oe before sync", {31'd0, du_oe}, 32'd0);
        end

        run_frame(3'd3, 1'b0, 32'hA5C3_1E6B, 32'h9E37_79B9);
        run_frame(3'd0, 1'b0, 32'hFFFF_FFFF, 32'hAAAA_5555);
        run_frame(3'd7, 1'b0, 32'h0000_0001, 32'hFFFF_FFFF);
        run_frame(3'd5, 1'b1, 32'h8001_7FFE, 32'h1234_5678);
        run_frame(3'd7, 1'b1, 32'hC0DE_F00D, 32'h8000_0001);
        run_frame(3'd2, 1'b0, 32'h5A5A_A5A5, 32'h0F0F_F0F0);

        repeat (20) @(posedge dcl);
        #(CLK_PERIOD / 4);
        check("R3 every slot word delivered", exp_q.size(), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule